// File: doc/BRIEF.md
# Per-core inter-processor interrupt register bank

This block holds the interrupt-request state and message mailbox of one processor core. Other agents post requests into a pending status word, either through a write-one-to-set register or through a direct vector-posting port used by a dispatcher. The core's own mask decides which pending bits may assert its interrupt line, and the core retires requests through a write-one-to-clear register. Eight 32-bit mailbox words in the same register window carry message data that senders deposit next to the interrupt.

The interrupt line is a held state, not a pure function of status and mask. A set event asserts it when the updated status shares a bit with the mask. A clear event deasserts it only when the updated status is zero and the mask is nonzero. Other accesses leave it where it is, and that includes writes to the mask. The register port decodes only the low eight address bits, takes one access per cycle, and returns read data one cycle after the request.

Top module: `ipi_core_bank`

## Requirements
- R1: After reset, status, mask, every mailbox word and the interrupt output are zero, and `bus_rvalid` is low.
- R2: A read request (`bus_req`=1, `bus_we`=0) gives `bus_rvalid`=1 with `bus_rdata` on the next cycle. Only `bus_addr[7:0]` is decoded, so offset 0x104 reaches the same register as 0x04.
- R3: Status is read at offset 0x00. A bus write to 0x00 leaves status unchanged.
- R4: A write to offset 0x04 loads the whole 32-bit mask, and a read of 0x04 returns it. A mask write does not change the interrupt output.
- R5: A write to offset 0x08 ORs the write data into status. After this set event, the interrupt goes to 1 if (status AND mask) is nonzero; otherwise it keeps its value.
- R6: A write to offset 0x0C clears the written bits from status. After this clear event, the interrupt goes to 0 only if status is zero and the mask is nonzero; otherwise it keeps its value, even when (status AND mask) is zero.
- R7: Reads of offsets 0x08 and 0x0C return zero.
- R8: Offsets 0x20 to 0x3F hold eight read/write mailbox words. The word index is (offset - 0x20) >> 2, so offset bits [1:0] are ignored (0x22 reaches word 0 and 0x3F reaches word 7).
- R9: Reads of any other offset (for example 0x10, 0x40, 0xFC) return zero, and writes to them change no register.
- R10: When `post_valid` is 1, bit `post_vec` (0 to 31) of status is set, and this counts as a set event under the R5 interrupt rule. If a clear write happens in the same cycle, the clear is applied first and the posted bit survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Access address; low 8 bits decoded |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| post_valid | input | 1 | Dispatcher posts an interrupt vector this cycle |
| post_vec | input | VEC_W (5) | Status bit to set when post_valid is 1 |
| irq | output | 1 | Interrupt line to the core |

## Verification
A wrong status word shows at the ports in two ways. A read of offset 0x00 exposes it one cycle after the request, and the interrupt line shows it in the cycle after the next set or clear event. A mask that was loaded wrongly, or an interrupt held under the wrong rule, shows up when a set leaves status and mask disjoint, when a clear leaves status nonzero, or when a clear to zero happens with the mask at zero. In each of these cases the line must keep its old value one cycle later. Mailbox index errors and address aliasing errors show in the read-back of a neighbouring word or an aliased offset, one cycle after the read.

// File: rtl/ipi_core_bank.sv
module ipi_core_bank #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  parameter int VEC_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              post_valid,
  input  logic [VEC_W-1:0]  post_vec,
  output logic              irq
);

  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_MASK   = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLR    = 8'h0C;
  localparam logic [7:0] MBOX_BASE  = 8'h20;
  localparam int         MBOX_END   = 32 + 4 * MBOX_WORDS;
  localparam int         MIDX_W     = $clog2(MBOX_WORDS);

  logic [DATA_W-1:0] status, mask;
  logic [DATA_W-1:0] mbox [MBOX_WORDS];
  logic [DATA_W-1:0] status_nx, set_bits, clr_bits, rd_mux;
  logic              irq_nx;

  wire [7:0]        off     = bus_addr[7:0];
  wire              wr      = bus_req && bus_we;
  wire              rd      = bus_req && !bus_we;
  wire              in_mbox = (off >= MBOX_BASE) && (int'(off) < MBOX_END);
  wire [7:0]        mb_off  = off - MBOX_BASE;
  wire [MIDX_W-1:0] mb_idx  = mb_off[MIDX_W+1:2];
  wire              set_evt = post_valid || (wr && off == OFF_SET);
  wire              clr_evt = wr && off == OFF_CLR;

  assign set_bits  = ((wr && off == OFF_SET) ? bus_wdata : '0)
                   | (post_valid ? (DATA_W'(1) << post_vec) : '0);
  assign clr_bits  = clr_evt ? bus_wdata : '0;
  assign status_nx = (status & ~clr_bits) | set_bits;

  always_comb begin
    irq_nx = irq;
    if (set_evt && |(status_nx & mask))
      irq_nx = 1'b1;
    else if (clr_evt && status_nx == '0 && |mask)
      irq_nx = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (off == OFF_STATUS)    rd_mux = status;
    else if (off == OFF_MASK) rd_mux = mask;
    else if (in_mbox)         rd_mux = mbox[mb_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status     <= '0;
      mask       <= '0;
      irq        <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      for (int i = 0; i < MBOX_WORDS; i++) mbox[i] <= '0;
    end else begin
      status     <= status_nx;
      irq        <= irq_nx;
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
      if (wr && off == OFF_MASK) mask <= bus_wdata;
      if (wr && in_mbox)         mbox[mb_idx] <= bus_wdata;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid); // R2
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_STATUS && !post_valid) |=> $stable(status)); // R3
  AST_MASK_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_MASK && !post_valid) |=> $stable(irq)); // R4
  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_SET) |=> ((($past(status) | $past(bus_wdata)) & ~status) == '0)); // R5
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_evt)); // R5
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !post_valid) |=> ((status & $past(bus_wdata)) == '0)); // R6
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status == '0 && $past(clr_evt))); // R6
  AST_PORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (off == OFF_SET || off == OFF_CLR)) |=> (bus_rdata == '0)); // R7
  AST_POST_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |=> status[$past(post_vec)]); // R10

endmodule

// File: tb/ipi_core_bank_tb.sv
module ipi_core_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        post_valid = 1'b0;
  logic [4:0]  post_vec = '0;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ipi_core_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .post_valid(post_valid), .post_vec(post_vec),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read response: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic post(input logic [4:0] v);
    @(negedge clk);
    post_valid = 1'b1; post_vec = v;
    @(negedge clk);
    post_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rvalid actual %b expected 0", bus_rvalid);
    end
    chk_irq(1'b0, "R1 reset irq");
    rst_n = 1'b1;
    rd(12'h000, 32'h0, "R1 status reset");
    rd(12'h004, 32'h0, "R1 mask reset");
    rd(12'h03C, 32'h0, "R1 mailbox reset");

    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0, "R3 status write ignored");

    wr(12'h008, 32'h5);
    chk_irq(1'b0, "R5 set with zero mask");
    wr(12'h004, 32'h4);
    chk_irq(1'b0, "R4 mask write keeps irq");
    rd(12'h004, 32'h4, "R4 mask readback");
    wr(12'h008, 32'h10);
    chk_irq(1'b1, "R5 set raises irq");
    rd(12'h000, 32'h15, "R5 status ORed");
    rd(12'h008, 32'h0, "R7 set port reads zero");
    rd(12'h00C, 32'h0, "R7 clear port reads zero");

    wr(12'h00C, 32'h4);
    chk_irq(1'b1, "R6 nonzero status holds irq");
    rd(12'h000, 32'h11, "R6 clear bits");
    wr(12'h00C, 32'h11);
    chk_irq(1'b0, "R6 clear to zero lowers irq");

    wr(12'h004, 32'h2);
    wr(12'h008, 32'h2);
    chk_irq(1'b1, "R5 raise again");
    wr(12'h004, 32'h0);
    wr(12'h00C, 32'h2);
    chk_irq(1'b1, "R6 zero mask holds irq");
    wr(12'h004, 32'h1);
    wr(12'h00C, 32'h0);
    chk_irq(1'b0, "R6 clear with mask lowers irq");

    for (int i = 0; i < 8; i++) wr(12'h020 + 12'(4 * i), 32'hA5A5_0000 + 32'(i));
    for (int i = 0; i < 8; i++) rd(12'h020 + 12'(4 * i), 32'hA5A5_0000 + 32'(i), "R8 mailbox word");
    rd(12'h03F, 32'hA5A5_0007, "R8 offset 0x3F is word 7");
    rd(12'h022, 32'hA5A5_0000, "R8 offset 0x22 is word 0");

    rd(12'h104, 32'h1, "R2 alias 0x104 reads mask");
    wr(12'h120, 32'hDEAD_BEEF);
    rd(12'h020, 32'hDEAD_BEEF, "R2 alias write to mailbox 0");

    rd(12'h010, 32'h0, "R9 undecoded 0x10");
    rd(12'h040, 32'h0, "R9 undecoded 0x40");
    wr(12'h040, 32'h1234_5678);
    wr(12'h0FC, 32'hFFFF_FFFF);
    rd(12'h0FC, 32'h0, "R9 undecoded 0xFC");
    rd(12'h03C, 32'hA5A5_0007, "R9 mailbox 7 untouched");
    rd(12'h000, 32'h0, "R9 status untouched");
    rd(12'h004, 32'h1, "R9 mask untouched");

    wr(12'h004, 32'h8);
    post(5'd3);
    chk_irq(1'b1, "R10 post raises irq");
    post(5'd31);
    rd(12'h000, 32'h8000_0008, "R10 posted bits");
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h00C; bus_wdata = 32'h8000_0008;
    post_valid = 1'b1; post_vec = 5'd31;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; post_valid = 1'b0;
    chk_irq(1'b1, "R10 post with clear holds irq");
    rd(12'h000, 32'h8000_0000, "R10 post survives clear");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: missing read responses actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule